// File: doc/BRIEF.md
# External-Interrupt Number Set/Clear Translator

This block accepts accesses aimed at a group of control registers that let software raise or drop one external-interrupt pending bit, or one enable bit, by writing the interrupt's identity number instead of a bit pattern. There are four such registers for each of the machine, supervisor and guest-supervisor views. For a write, the block turns the number into an indirect word select, a one-hot bit mask and a write value, and issues one masked write to the interrupt file that owns that view. Guest-supervisor writes go to the guest file that the hypervisor's guest-select field names.

An access that cannot reach a file is answered with a fault. The fault is a virtual-instruction fault when the hart runs virtualized and the access targets the guest view. Every other failure raises an illegal-instruction fault. Reads always return zero. A small behavioural interrupt-file model, `eint_file_stub`, comes with the block so the write strobe can be seen landing in real pending and enable bits.

Top module: `eint_num_xlate`

## Requirements
- R1: The register address selects the view through bits [11:2]: group 0x0D6 (0x358..0x35B) is machine, 0x056 (0x158..0x15B) is supervisor and 0x096 (0x258..0x25B) is guest-supervisor. Bits [1:0] select the operation: 0 set pending, 1 clear pending, 2 set enable, 3 clear enable. An accepted access in one of these groups gives `rsp_valid` for exactly one cycle, one clock edge later. Any other address gives no response and no file write.
- R2: When `req_virt` is 1, a supervisor-group address is handled as the guest-supervisor register with the same low two bits.
- R3: `rsp_rdata` is zero on every response.
- R4: The number is `req_wdata & req_wmask`. The word select is (number / XLEN) * (XLEN/32) plus a base: PEND_BASE (0x80) for pending operations and EN_BASE (0xC0) for enable operations, truncated to SEL_W bits.
- R5: `fw_mask` has a single one at bit (number mod XLEN). `fw_value` equals `fw_mask` for set operations and is zero for clear operations.
- R6: `fw_level` is 0 for machine, 1 for supervisor and 2 for guest-supervisor. `fw_guest` is `req_vgein` for guest-supervisor writes and 0 otherwise.
- R7: A guest-supervisor access fails when `req_vgein` is 0 or greater than NUM_GUESTS.
- R8: A machine access fails when `file_present[0]` is 0. A supervisor or guest-supervisor access fails when `file_present[1]` is 0.
- R9: A failed access sets `rsp_virt_fault` if `req_virt` is 1 and the target is the guest view, and sets `rsp_illegal` otherwise. It never produces a file write, and the two fault flags are never both set.
- R10: A legal access with `req_wmask` equal to zero succeeds with no fault and no file write. The fault checks still apply to it.
- R11: In the file model, file index 0 is machine, 1 is supervisor and 1+g is guest g. A write at select PEND_BASE+k (or EN_BASE+k) updates the pending (or enable) ids 32k+i for every set mask bit i, taking bit i of the value, for ids below NUM_IDS. All other bits keep their values.
- R12: `req_ready` is always 1. An access is accepted on every cycle where `req_valid` is 1, so back-to-back accesses produce back-to-back responses with no back-pressure.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Always 1; the block never stalls |
| req_addr | input | 12 | Register address |
| req_wdata | input | XLEN | Written value (interrupt number) |
| req_wmask | input | XLEN | Write mask of the access; zero for a pure read |
| req_virt | input | 1 | Hart is running virtualized |
| req_vgein | input | GUEST_W | Hypervisor guest-file select |
| file_present | input | 2 | Bit 0: machine file exists; bit 1: supervisor/guest files exist |
| rsp_valid | output | 1 | Response for the access accepted on the previous edge |
| rsp_rdata | output | XLEN | Read data, always zero |
| rsp_illegal | output | 1 | Illegal-instruction fault |
| rsp_virt_fault | output | 1 | Virtual-instruction fault |
| fw_valid | output | 1 | One-cycle file write strobe |
| fw_level | output | 2 | Target view: 0 machine, 1 supervisor, 2 guest |
| fw_guest | output | GUEST_W | Guest file index (0 unless guest view) |
| fw_sel | output | SEL_W | Indirect word select |
| fw_mask | output | XLEN | One-hot bit mask |
| fw_value | output | XLEN | Value for the masked bit |

## Verification
The bench builds the block with XLEN = 64, NUM_GUESTS = 4, SEL_W = 8 and the default bases, and the file model with 64 ids per array. With 64-bit words each select covers two 32-bit slots, so the stride of two and the modulo-64 bit position are both exercised. A guest range of four lets a random select in 0..6 hit both edges of the valid range (0 and 5 fail, 1 and 4 pass). Random numbers past 64 make the select wrap through the 8-bit width into the other array's base and past the modelled ids, which tests the truncation and the model's range guard.

// File: rtl/eint_xlate_pkg.sv
package eint_xlate_pkg;

  typedef enum logic [1:0] {
    LVL_M  = 2'd0,
    LVL_S  = 2'd1,
    LVL_VS = 2'd2
  } lvl_e;

  typedef enum logic [1:0] {
    OP_SET_PEND = 2'd0,
    OP_CLR_PEND = 2'd1,
    OP_SET_EN   = 2'd2,
    OP_CLR_EN   = 2'd3
  } op_e;

  localparam logic [9:0] GRP_M  = 10'h0D6;
  localparam logic [9:0] GRP_S  = 10'h056;
  localparam logic [9:0] GRP_VS = 10'h096;

endpackage

// File: rtl/eint_csr_decode.sv
module eint_csr_decode
  import eint_xlate_pkg::*;
(
  input  logic [11:0] addr,
  input  logic        virt,
  output logic        hit,
  output lvl_e        lvl,
  output op_e         op
);
  always_comb begin
    hit = 1'b1;
    lvl = LVL_M;
    op  = op_e'(addr[1:0]);
    case (addr[11:2])
      GRP_M:   lvl = LVL_M;
      GRP_S:   lvl = virt ? LVL_VS : LVL_S;
      GRP_VS:  lvl = LVL_VS;
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/eint_write_gen.sv
module eint_write_gen
  import eint_xlate_pkg::*;
#(
  parameter int          XLEN      = 64,
  parameter int          SEL_W     = 8,
  parameter int unsigned PEND_BASE = 'h80,
  parameter int unsigned EN_BASE   = 'hC0
) (
  input  logic [XLEN-1:0]  wdata,
  input  logic [XLEN-1:0]  wmask,
  input  op_e              op,
  output logic [SEL_W-1:0] sel,
  output logic [XLEN-1:0]  mask,
  output logic [XLEN-1:0]  value
);
  localparam int SH   = $clog2(XLEN);
  localparam int STEP = XLEN / 32;

  logic [XLEN-1:0] num;
  logic [XLEN-1:0] word_scaled;
  logic            is_set;
  logic            is_pend;

  always_comb begin
    num         = wdata & wmask;
    word_scaled = (num >> SH) * XLEN'(STEP);
    is_set      = (op == OP_SET_PEND) || (op == OP_SET_EN);
    is_pend     = (op == OP_SET_PEND) || (op == OP_CLR_PEND);
    sel         = word_scaled[SEL_W-1:0] +
                  (is_pend ? SEL_W'(PEND_BASE) : SEL_W'(EN_BASE));
    mask        = XLEN'(1) << num[SH-1:0];
    value       = is_set ? mask : '0;
  end
endmodule

// File: rtl/eint_access_check.sv
module eint_access_check
  import eint_xlate_pkg::*;
#(
  parameter int NUM_GUESTS = 4,
  parameter int GUEST_W    = 6
) (
  input  logic               hit,
  input  lvl_e               lvl,
  input  logic               virt,
  input  logic [GUEST_W-1:0] vgein,
  input  logic [1:0]         file_present,
  output logic               fail,
  output logic               pick_virt_fault,
  output logic [GUEST_W-1:0] guest
);
  logic no_file;
  logic bad_guest;

  always_comb begin
    no_file         = (lvl == LVL_M) ? !file_present[0] : !file_present[1];
    bad_guest       = (lvl == LVL_VS) &&
                      ((vgein == '0) || (vgein > GUEST_W'(NUM_GUESTS)));
    fail            = hit && (no_file || bad_guest);
    pick_virt_fault = virt && (lvl == LVL_VS);
    guest           = (lvl == LVL_VS) ? vgein : '0;
  end
endmodule

// File: rtl/eint_file_stub.sv
module eint_file_stub #(
  parameter int          XLEN       = 64,
  parameter int          NUM_GUESTS = 4,
  parameter int          GUEST_W    = 6,
  parameter int          SEL_W      = 8,
  parameter int unsigned PEND_BASE  = 'h80,
  parameter int unsigned EN_BASE    = 'hC0,
  parameter int          NUM_IDS    = 64,
  localparam int         NFILES     = 2 + NUM_GUESTS,
  localparam int         FILE_W     = $clog2(NFILES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fw_valid,
  input  logic [1:0]         fw_level,
  input  logic [GUEST_W-1:0] fw_guest,
  input  logic [SEL_W-1:0]   fw_sel,
  input  logic [XLEN-1:0]    fw_mask,
  input  logic [XLEN-1:0]    fw_value,
  input  logic [FILE_W-1:0]  rd_file,
  input  logic               rd_enable,
  output logic [NUM_IDS-1:0] rd_bits
);
  localparam int WORDS = NUM_IDS / 32;
  localparam int SH    = $clog2(XLEN);

  logic [NUM_IDS-1:0] pend_q [NFILES];
  logic [NUM_IDS-1:0] en_q   [NFILES];
  logic [NUM_IDS-1:0] upd_mask, upd_val;
  logic               in_pend, in_en;
  int                 fidx;
  int                 base_id;
  logic [31:0]        rel;

  always_comb begin
    in_pend  = (int'(fw_sel) >= int'(PEND_BASE)) && (int'(fw_sel) < int'(PEND_BASE) + WORDS);
    in_en    = (int'(fw_sel) >= int'(EN_BASE))   && (int'(fw_sel) < int'(EN_BASE) + WORDS);
    base_id  = (int'(fw_sel) - (in_pend ? int'(PEND_BASE) : int'(EN_BASE))) * 32;
    fidx     = (fw_level == 2'd0) ? 0 : (fw_level == 2'd1) ? 1 : 1 + int'(fw_guest);
    upd_mask = '0;
    upd_val  = '0;
    for (int i = 0; i < NUM_IDS; i++) begin
      rel = 32'(i - base_id);
      if ((i >= base_id) && (i - base_id < XLEN)) begin
        upd_mask[i] = fw_mask[rel[SH-1:0]];
        upd_val[i]  = fw_value[rel[SH-1:0]];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int f = 0; f < NFILES; f++) begin
        pend_q[f] <= '0;
        en_q[f]   <= '0;
      end
    end else if (fw_valid && (fidx < NFILES)) begin
      if (in_pend) pend_q[fidx] <= (pend_q[fidx] & ~upd_mask) | (upd_val & upd_mask);
      if (in_en)   en_q[fidx]   <= (en_q[fidx] & ~upd_mask) | (upd_val & upd_mask);
    end
  end

  always_comb begin
    rd_bits = '0;
    if (int'(rd_file) < NFILES) rd_bits = rd_enable ? en_q[rd_file] : pend_q[rd_file];
  end
endmodule

// File: rtl/eint_num_xlate.sv
module eint_num_xlate
  import eint_xlate_pkg::*;
#(
  parameter int          XLEN       = 64,
  parameter int          NUM_GUESTS = 4,
  parameter int          GUEST_W    = 6,
  parameter int          SEL_W      = 8,
  parameter int unsigned PEND_BASE  = 'h80,
  parameter int unsigned EN_BASE    = 'hC0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [11:0]        req_addr,
  input  logic [XLEN-1:0]    req_wdata,
  input  logic [XLEN-1:0]    req_wmask,
  input  logic               req_virt,
  input  logic [GUEST_W-1:0] req_vgein,
  input  logic [1:0]         file_present,
  output logic               rsp_valid,
  output logic [XLEN-1:0]    rsp_rdata,
  output logic               rsp_illegal,
  output logic               rsp_virt_fault,
  output logic               fw_valid,
  output logic [1:0]         fw_level,
  output logic [GUEST_W-1:0] fw_guest,
  output logic [SEL_W-1:0]   fw_sel,
  output logic [XLEN-1:0]    fw_mask,
  output logic [XLEN-1:0]    fw_value
);
  logic               hit;
  lvl_e               lvl;
  op_e                op;
  logic [SEL_W-1:0]   sel_c;
  logic [XLEN-1:0]    mask_c, value_c;
  logic               fail_c, vfault_c;
  logic [GUEST_W-1:0] guest_c;
  logic               acc, do_write;

  eint_csr_decode u_dec (
    .addr (req_addr),
    .virt (req_virt),
    .hit  (hit),
    .lvl  (lvl),
    .op   (op)
  );

  eint_write_gen #(
    .XLEN(XLEN), .SEL_W(SEL_W), .PEND_BASE(PEND_BASE), .EN_BASE(EN_BASE)
  ) u_gen (
    .wdata (req_wdata),
    .wmask (req_wmask),
    .op    (op),
    .sel   (sel_c),
    .mask  (mask_c),
    .value (value_c)
  );

  eint_access_check #(.NUM_GUESTS(NUM_GUESTS), .GUEST_W(GUEST_W)) u_chk_acc (
    .hit             (hit),
    .lvl             (lvl),
    .virt            (req_virt),
    .vgein           (req_vgein),
    .file_present    (file_present),
    .fail            (fail_c),
    .pick_virt_fault (vfault_c),
    .guest           (guest_c)
  );

  assign req_ready = 1'b1;
  assign rsp_rdata = '0;
  assign acc       = req_valid && hit;
  assign do_write  = acc && !fail_c && (req_wmask != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid      <= 1'b0;
      rsp_illegal    <= 1'b0;
      rsp_virt_fault <= 1'b0;
      fw_valid       <= 1'b0;
      fw_level       <= '0;
      fw_guest       <= '0;
      fw_sel         <= '0;
      fw_mask        <= '0;
      fw_value       <= '0;
    end else begin
      rsp_valid      <= acc;
      rsp_illegal    <= acc && fail_c && !vfault_c;
      rsp_virt_fault <= acc && fail_c && vfault_c;
      fw_valid       <= do_write;
      if (do_write) begin
        fw_level <= lvl;
        fw_guest <= guest_c;
        fw_sel   <= sel_c;
        fw_mask  <= mask_c;
        fw_value <= value_c;
      end
    end
  end
endmodule

// File: rtl/eint_num_xlate_chk.sv
module eint_num_xlate_chk #(
  parameter int XLEN       = 64,
  parameter int NUM_GUESTS = 4,
  parameter int GUEST_W    = 6,
  parameter int SEL_W      = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic [11:0]        req_addr,
  input logic [XLEN-1:0]    req_wmask,
  input logic [1:0]         file_present,
  input logic               rsp_valid,
  input logic               rsp_illegal,
  input logic               rsp_virt_fault,
  input logic               fw_valid,
  input logic [1:0]         fw_level,
  input logic [GUEST_W-1:0] fw_guest,
  input logic [XLEN-1:0]    fw_mask,
  input logic [XLEN-1:0]    fw_value
);
  logic in_map, m_grp;
  assign m_grp  = (req_addr[11:2] == 10'h0D6);
  assign in_map = m_grp || (req_addr[11:2] == 10'h056) || (req_addr[11:2] == 10'h096);

  a_r1_resp_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && in_map |=> rsp_valid);
  a_r1_silent_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && in_map) |=> !rsp_valid && !fw_valid);
  a_r5_onehot_mask: assert property (@(posedge clk) disable iff (!rst_n)
    fw_valid |-> $countones(fw_mask) == 1);
  a_r5_value_form: assert property (@(posedge clk) disable iff (!rst_n)
    fw_valid |-> (fw_value == fw_mask) || (fw_value == '0));
  a_r6_guest_zero: assert property (@(posedge clk) disable iff (!rst_n)
    fw_valid && fw_level != 2'd2 |-> fw_guest == '0);
  a_r7_guest_range: assert property (@(posedge clk) disable iff (!rst_n)
    fw_valid && fw_level == 2'd2 |-> fw_guest != '0 && fw_guest <= GUEST_W'(NUM_GUESTS));
  a_r8_no_sfile: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && in_map && !m_grp && !file_present[1] |=> !fw_valid && (rsp_illegal || rsp_virt_fault));
  a_r9_single_fault: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_illegal && rsp_virt_fault));
  a_r9_fault_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_illegal || rsp_virt_fault |-> rsp_valid && !fw_valid);
  a_r10_zero_mask: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_wmask == '0 |=> !fw_valid);
endmodule

bind eint_num_xlate eint_num_xlate_chk #(
  .XLEN(XLEN), .NUM_GUESTS(NUM_GUESTS), .GUEST_W(GUEST_W), .SEL_W(SEL_W)
) u_xlate_chk (.*);

// File: tb/eint_num_xlate_bench.sv
`timescale 1ns/1ps
module eint_num_xlate_bench;
  localparam int XLEN = 64, NG = 4, GW = 6, SW = 8, NIDS = 64, NF = 2 + NG;
  localparam int PB = 'h80, EB = 'hC0;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic req_valid = 0, req_ready, req_virt = 0;
  logic [11:0] req_addr = '0;
  logic [XLEN-1:0] req_wdata = '0, req_wmask = '0;
  logic [GW-1:0] req_vgein = '0;
  logic [1:0] file_present = 2'b11;
  logic rsp_valid, rsp_illegal, rsp_virt_fault, fw_valid;
  logic [XLEN-1:0] rsp_rdata, fw_mask, fw_value;
  logic [1:0] fw_level;
  logic [GW-1:0] fw_guest;
  logic [SW-1:0] fw_sel;
  logic [2:0] rd_file = '0;
  logic rd_enable = 0;
  logic [NIDS-1:0] rd_bits;

  eint_num_xlate u_eint_num_xlate (.*);
  eint_file_stub u_stub (.clk, .rst_n, .fw_valid, .fw_level, .fw_guest, .fw_sel,
    .fw_mask, .fw_value, .rd_file, .rd_enable, .rd_bits);

  int checks = 0, fails = 0;
  logic [NIDS-1:0] m_pend [NF];
  logic [NIDS-1:0] m_en [NF];

  task automatic chk(string tag, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(logic [11:0] a, logic v, logic [GW-1:0] g, logic [1:0] fp,
                        logic [XLEN-1:0] wd, logic [XLEN-1:0] wm);
    logic hit, bad, e_ill, e_vf, e_fw;
    logic [1:0] lvl;
    logic [XLEN-1:0] num, e_mask, e_val;
    logic [SW-1:0] e_sel;
    logic [GW-1:0] e_g;
    int fi;
    req_valid = 1; req_addr = a; req_virt = v; req_vgein = g; file_present = fp;
    req_wdata = wd; req_wmask = wm;
    hit = 1; lvl = 0;
    if (a[11:2] == 10'h0D6) lvl = 0;
    else if (a[11:2] == 10'h056) lvl = v ? 2 : 1;
    else if (a[11:2] == 10'h096) lvl = 2;
    else hit = 0;
    bad = ((lvl == 0) ? !fp[0] : !fp[1]) || (lvl == 2 && (g == 0 || g > NG));
    e_ill = hit && bad && !(v && lvl == 2);
    e_vf  = hit && bad && (v && lvl == 2);
    e_fw  = hit && !bad && (wm != 0);
    num    = wd & wm;
    e_sel  = SW'((num / XLEN) * (XLEN / 32) + (a[1] ? EB : PB));
    e_mask = XLEN'(1) << (num % XLEN);
    e_val  = a[0] ? '0 : e_mask;
    e_g    = (lvl == 2) ? g : '0;
    @(posedge clk); #1;
    chk("R1 rsp_valid", XLEN'(rsp_valid), XLEN'(hit));
    chk("R3 rdata", rsp_rdata, '0);
    chk("R9 illegal", XLEN'(rsp_illegal), XLEN'(e_ill));
    chk("R9 virt_fault", XLEN'(rsp_virt_fault), XLEN'(e_vf));
    chk("R10 fw_valid", XLEN'(fw_valid), XLEN'(e_fw));
    chk("R12 ready", XLEN'(req_ready), 1);
    if (e_fw && fw_valid) begin
      chk("R6 level", XLEN'(fw_level), XLEN'(lvl));
      chk("R6 guest", XLEN'(fw_guest), XLEN'(e_g));
      chk("R4 sel", XLEN'(fw_sel), XLEN'(e_sel));
      chk("R5 mask", fw_mask, e_mask);
      chk("R5 value", fw_value, e_val);
      fi = (lvl == 0) ? 0 : (lvl == 1) ? 1 : 1 + int'(g);
      for (int k = 0; k < NIDS / 32; k++) begin
        if (int'(e_sel) == PB + k)
          m_pend[fi] = (m_pend[fi] & ~(e_mask << (32 * k))) | (e_val << (32 * k));
        if (int'(e_sel) == EB + k)
          m_en[fi] = (m_en[fi] & ~(e_mask << (32 * k))) | (e_val << (32 * k));
      end
    end
  endtask

  task automatic idle();
    req_valid = 0; req_wmask = '0;
    @(posedge clk); #1;
    chk("R1 idle no rsp", XLEN'(rsp_valid), 0);
  endtask

  task automatic check_files();
    idle(); idle();
    for (int f = 0; f < NF; f++) begin
      rd_file = 3'(f); rd_enable = 0; #1;
      chk("R11 pending bits", rd_bits, m_pend[f]);
      rd_enable = 1; #1;
      chk("R11 enable bits", rd_bits, m_en[f]);
    end
  endtask

  localparam logic [XLEN-1:0] ONES = '1;

  initial begin
    int seed, r;
    logic [11:0] a;
    logic [XLEN-1:0] wd, wm;
    seed = 7;
    r = $urandom(seed);
    for (int f = 0; f < NF; f++) begin m_pend[f] = '0; m_en[f] = '0; end
    #1;
    chk("R1 reset rsp_valid", XLEN'(rsp_valid), 0);
    chk("R10 reset fw_valid", XLEN'(fw_valid), 0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;
    // directed corner cases
    access(12'h358, 0, 0, 2'b11, 0, ONES);          // R5 set pend id 0 machine
    access(12'h35A, 0, 0, 2'b11, 63, ONES);         // R5 set enable id 63
    access(12'h159, 0, 0, 2'b11, 5, ONES);          // R1 clear pending supervisor
    access(12'h158, 1, 3, 2'b11, 9, ONES);          // R2 redirect to guest 3
    access(12'h258, 1, 0, 2'b11, 1, ONES);          // R7 guest 0 virt fault
    access(12'h258, 0, 5, 2'b11, 1, ONES);          // R7 guest 5 illegal
    access(12'h25A, 0, 4, 2'b11, 2, ONES);          // R7 guest 4 legal
    access(12'h358, 0, 0, 2'b10, 3, ONES);          // R8 no machine file
    access(12'h15B, 0, 0, 2'b01, 3, ONES);          // R8 no supervisor file
    access(12'h358, 0, 0, 2'b11, 4, '0);            // R10 zero mask
    access(12'h258, 1, 0, 2'b11, 4, '0);            // R10 zero mask still faults
    access(12'h35C, 0, 0, 2'b11, 4, ONES);          // R1 outside map
    access(12'h35B, 0, 0, 2'b11, 64'hFF, 64'h0F);   // R4 masked number 15
    access(12'h35A, 0, 0, 2'b11, 200, ONES);        // R4 word 3 select
    idle();
    check_files();
    // constrained random
    for (int n = 0; n < 800; n++) begin
      case ($urandom % 4)
        0: a = 12'h358; 1: a = 12'h158; 2: a = 12'h258;
        default: a = 12'($urandom);
      endcase
      a[1:0] = 2'($urandom);
      wd = XLEN'($urandom % NIDS);
      if ($urandom % 8 == 0) wd = {32'($urandom), 32'($urandom)};
      wm = ONES;
      if ($urandom % 10 == 0) wm = '0;
      else if ($urandom % 10 == 0) wm = XLEN'($urandom);
      access(a, 1'($urandom), GW'($urandom % 7),
             ($urandom % 6 == 0) ? 2'($urandom) : 2'b11, wd, wm);
      if ($urandom % 5 == 0) idle();
    end
    check_files();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule